// File: doc/BRIEF.md
# Burst Column Order Generator

This block turns one burst request into the per-beat column addresses that a DDR2-style memory burst visits. A request pulse carries a start column, a burst length code and a burst type bit. The block then emits one column address per clock with a valid flag, and raises a last-beat flag on the final beat. The lowest three column bits follow the selected ordering rule. The bits above them pass through unchanged from the start column.

Two ordering rules are supported. Sequential order counts upward and wraps inside a group of four beats. In an 8-beat burst the second four beats then continue in the other group of four. Interleaved order is the start offset XOR the beat number. A new request that arrives on the final beat of a burst starts the next burst with no gap. A request during the earlier beats of a burst is dropped and reported. A request with a length other than 4 or 8 is refused and reported.

Top module: `burst_colseq`

## Requirements
- R1: `len_i` = 4 gives exactly 4 valid beats and `len_i` = 8 gives exactly 8. An accepted request with any other `len_i` starts no burst (`valid_o` stays 0) and pulses `err_o` high for the one cycle after it.
- R2: `btype_i` = 0 selects sequential order and `btype_i` = 1 selects interleaved order. Both are sampled with the request.
- R3: Sequential, length 4, start offset s, beat k: `col_o[1:0]` = (s + k) mod 4, and `col_o[2]` equals start bit 2.
- R4: Sequential, length 8: `col_o[1:0]` = (s + k) mod 4, and `col_o[2]` = s[2] XOR k[2]. For example, start 5 gives 5,6,7,4,1,2,3,0.
- R5: Interleaved order gives `col_o[2:0]` = s XOR k for length 8. For length 4 it gives `col_o[1:0]` = s[1:0] XOR k[1:0], with `col_o[2]` = s[2].
- R6: When `start_i` is sampled high at a clock edge and a request is accepted, beat 0 is driven in the following cycle. Beats then follow on consecutive cycles. `valid_o` drops after the last beat unless a new burst follows.
- R7: `last_o` is high only on beat 3 of a length-4 burst or beat 7 of a length-8 burst.
- R8: A request sampled in the cycle of the last beat is accepted. Its beat 0 appears in the very next cycle.
- R9: A request sampled while a beat other than the last is being driven is ignored, and the burst continues unchanged. `collide_o` is high for the one cycle after that request.
- R10: `col_o[COL_W-1:3]` equals the start column's upper bits on every beat of a burst. `col_o` is 0 while `valid_o` is 0.
- R11: While reset is asserted, `valid_o`, `last_o`, `collide_o`, `err_o` and `col_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Burst request pulse |
| len_i | input | LEN_W (4) | Burst length code, 4 or 8 |
| btype_i | input | 1 | Burst type: 0 sequential, 1 interleaved |
| start_col_i | input | COL_W (10) | Start column address |
| col_o | output | COL_W (10) | Column address of the current beat |
| valid_o | output | 1 | A beat is driven this cycle |
| last_o | output | 1 | Current beat is the final one |
| collide_o | output | 1 | A request was ignored during a burst |
| err_o | output | 1 | A request had an unsupported length |

## Verification
A corrupted beat counter or a mis-latched start offset shows on `col_o` in the same cycle as the beat it affects. A wrong stored length moves `last_o`, and with it the end of `valid_o`, by four cycles. Any of these faults therefore appears within at most eight cycles of the request. A wrong acceptance decision shows one cycle after the request, as a missing or extra beat 0, or as a `collide_o` or `err_o` pulse that should not be there.

// File: rtl/burst_colseq_pkg.sv
package burst_colseq_pkg;

  localparam int ORD_W  = 3;
  localparam int BEAT_W = 3;

  // Offset of beat k inside the ordering field, from start offset s.
  function automatic logic [ORD_W-1:0] beat_offset(
    input logic [ORD_W-1:0]  s,
    input logic [BEAT_W-1:0] k,
    input logic              len8,
    input logic              ilv
  );
    logic [ORD_W-1:0] r;
    if (ilv) begin
      r = len8 ? (s ^ k) : {s[2], s[1:0] ^ k[1:0]};
    end else begin
      r[1:0] = s[1:0] + k[1:0];
      r[2]   = len8 ? (s[2] ^ k[2]) : s[2];
    end
    return r;
  endfunction

  function automatic logic length_supported(input logic [3:0] l);
    return (l == 4'd4) || (l == 4'd8);
  endfunction

  function automatic logic [BEAT_W-1:0] final_beat(input logic len8);
    return len8 ? 3'd7 : 3'd3;
  endfunction

endpackage

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl
  import burst_colseq_pkg::*;
#(
  parameter int COL_W = 10,
  parameter int LEN_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [LEN_W-1:0]    len_i,
  input  logic                btype_i,
  input  logic [COL_W-1:0]    start_col_i,
  output logic                active_o,
  output logic [BEAT_W-1:0]   beat_o,
  output logic                len8_o,
  output logic                ilv_o,
  output logic [COL_W-1:0]    base_o,
  output logic                last_o,
  output logic                accept_o,
  output logic                go_o,
  output logic                collide_o,
  output logic                err_o
);

  logic len_good;

  assign len_good = length_supported(len_i[3:0]) &&
                    ((LEN_W <= 4) || (len_i >> 4) == '0);
  assign last_o   = active_o && (beat_o == final_beat(len8_o));
  assign accept_o = start_i && (!active_o || last_o);
  assign go_o     = accept_o && len_good;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_o  <= 1'b0;
      beat_o    <= '0;
      len8_o    <= 1'b0;
      ilv_o     <= 1'b0;
      base_o    <= '0;
      collide_o <= 1'b0;
      err_o     <= 1'b0;
    end else begin
      collide_o <= start_i && active_o && !last_o;
      err_o     <= accept_o && !len_good;
      if (go_o) begin
        active_o <= 1'b1;
        beat_o   <= '0;
        len8_o   <= (len_i[3:0] == 4'd8);
        ilv_o    <= btype_i;
        base_o   <= start_col_i;
      end else if (last_o) begin
        active_o <= 1'b0;
        beat_o   <= '0;
      end else if (active_o) begin
        beat_o   <= beat_o + 1'b1;
      end
    end
  end

endmodule

// File: rtl/burst_col_map.sv
module burst_col_map
  import burst_colseq_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic              active_i,
  input  logic [BEAT_W-1:0] beat_i,
  input  logic              len8_i,
  input  logic              ilv_i,
  input  logic [COL_W-1:0]  base_i,
  output logic [COL_W-1:0]  col_o
);

  localparam int UP_W = COL_W - ORD_W;

  logic [ORD_W-1:0] offset;

  assign offset = beat_offset(base_i[ORD_W-1:0], beat_i, len8_i, ilv_i);

  generate
    if (UP_W > 0) begin : g_upper
      assign col_o = active_i ? {base_i[COL_W-1:ORD_W], offset} : '0;
    end else begin : g_no_upper
      assign col_o = active_i ? offset[COL_W-1:0] : '0;
    end
  endgenerate

endmodule

// File: rtl/burst_colseq.sv
module burst_colseq
  import burst_colseq_pkg::*;
#(
  parameter int COL_W = 10,
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             btype_i,
  input  logic [COL_W-1:0] start_col_i,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o,
  output logic             last_o,
  output logic             collide_o,
  output logic             err_o
);

  logic              active_w;
  logic [BEAT_W-1:0] beat_w;
  logic              len8_w;
  logic              ilv_w;
  logic [COL_W-1:0]  base_w;
  logic              accept_w;
  logic              go_w;

  burst_seq_ctrl #(.COL_W(COL_W), .LEN_W(LEN_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .len_i       (len_i),
    .btype_i     (btype_i),
    .start_col_i (start_col_i),
    .active_o    (active_w),
    .beat_o      (beat_w),
    .len8_o      (len8_w),
    .ilv_o       (ilv_w),
    .base_o      (base_w),
    .last_o      (last_o),
    .accept_o    (accept_w),
    .go_o        (go_w),
    .collide_o   (collide_o),
    .err_o       (err_o)
  );

  burst_col_map #(.COL_W(COL_W)) u_map (
    .active_i (active_w),
    .beat_i   (beat_w),
    .len8_i   (len8_w),
    .ilv_i    (ilv_w),
    .base_i   (base_w),
    .col_o    (col_o)
  );

  assign valid_o = active_w;

endmodule

// File: rtl/burst_colseq_chk.sv
module burst_colseq_chk #(
  parameter int COL_W = 10,
  parameter int LEN_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic [LEN_W-1:0] len_i,
  input logic [COL_W-1:0] start_col_i,
  input logic [COL_W-1:0] col_o,
  input logic             valid_o,
  input logic             last_o,
  input logic             collide_o,
  input logic             err_o,
  input logic             go_w
);

  // R7
  last_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |-> valid_o);

  // R6
  first_beat_is_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go_w |=> valid_o && col_o == $past(start_col_i));

  // R6
  burst_continues_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o && !last_o |=> valid_o);

  // R6
  burst_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o && last_o && !start_i |=> !valid_o);

  // R10
  upper_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o && !last_o |=> col_o[COL_W-1:3] == $past(col_o[COL_W-1:3]));

  // R10
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> col_o == '0);

  // R9
  collide_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && valid_o && !last_o |=> collide_o && valid_o);

  // R1
  bad_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && (!valid_o || last_o) && len_i != 4 && len_i != 8
      |=> err_o && !valid_o);

  // R1
  err_needs_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> !err_o && !collide_o);

endmodule

bind burst_colseq burst_colseq_chk #(.COL_W(COL_W), .LEN_W(LEN_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .len_i       (len_i),
  .start_col_i (start_col_i),
  .col_o       (col_o),
  .valid_o     (valid_o),
  .last_o      (last_o),
  .collide_o   (collide_o),
  .err_o       (err_o),
  .go_w        (go_w)
);

// File: tb/tb_burst_colseq.sv
module tb_burst_colseq;

  localparam int COL_W = 10;
  localparam int LEN_W = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start_i = 1'b0;
  logic [LEN_W-1:0] len_i = '0;
  logic             btype_i = 1'b0;
  logic [COL_W-1:0] start_col_i = '0;
  logic [COL_W-1:0] col_o;
  logic             valid_o, last_o, collide_o, err_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  burst_colseq #(.COL_W(COL_W), .LEN_W(LEN_W)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .len_i(len_i),
    .btype_i(btype_i), .start_col_i(start_col_i), .col_o(col_o),
    .valid_o(valid_o), .last_o(last_o), .collide_o(collide_o), .err_o(err_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Expected low three column bits, restated arithmetically.
  function automatic int exp_low(int s, int k, int len, int typ);
    if (typ == 1) begin
      if (len == 8) return s ^ k;
      return (s & 4) | ((s ^ k) & 3);
    end
    if (len == 4) return (s & 4) | ((s + k) % 4);
    return (((s / 4 + k / 4) % 2) * 4) + ((s + k) % 4);
  endfunction

  // Called at a falling edge. Returns at the falling edge showing the last beat.
  task automatic run_burst(input int s, input int len, input int typ,
                           input int up, input int coll_at, input bit b2b);
    int n;
    string tag;
    n = len;
    tag = (typ == 1) ? "R5" : ((len == 8) ? "R4" : "R3");
    start_i = 1'b1; len_i = len[LEN_W-1:0]; btype_i = typ[0];
    start_col_i = COL_W'(up * 8 + s);
    @(negedge clk);
    start_i = 1'b0;
    for (int k = 0; k < n; k++) begin
      if (k > 0) @(negedge clk);
      if (coll_at >= 0 && k == coll_at + 1) begin
        chk("R9 collide", int'(collide_o), 1);
        start_i = 1'b0;
      end
      chk(k == 0 ? (b2b ? "R8 valid" : "R6 valid") : "R1 valid", int'(valid_o), 1);
      chk({tag, " order"}, int'(col_o[2:0]), exp_low(s, k, len, typ));
      chk("R10 upper", int'(col_o[COL_W-1:3]), up);
      chk("R7 last", int'(last_o), (k == n - 1) ? 1 : 0);
      if (k == coll_at) begin
        start_i = 1'b1; len_i = 4'd4; btype_i = ~typ[0];
        start_col_i = ~start_col_i;
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 valid", int'(valid_o), 0);
    chk("R11 last", int'(last_o), 0);
    chk("R11 col", int'(col_o), 0);
    chk("R11 collide", int'(collide_o), 0);
    chk("R11 err", int'(err_o), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2..R5 sweep over every start, length and type; odd ones back-to-back (R8)
    begin
      int idx = 0;
      for (int s = 0; s < 8; s++)
        for (int li = 0; li < 2; li++)
          for (int typ = 0; typ < 2; typ++) begin
            bit b2b = (idx % 2 == 1);
            if (!b2b && idx > 0) begin
              @(negedge clk);
              chk("R6 idle", int'(valid_o), 0);
              chk("R10 idle col", int'(col_o), 0);
            end
            run_burst(s, li ? 8 : 4, typ, (s * 37 + li * 11 + typ * 5) % 128, -1, b2b);
            idx++;
          end
    end
    @(negedge clk);
    chk("R6 end", int'(valid_o), 0);

    // R9 collisions during bursts
    run_burst(5, 8, 0, 93, 2, 1'b0);
    @(negedge clk);
    chk("R9 no extra burst", int'(valid_o), 0);
    run_burst(3, 4, 1, 17, 1, 1'b0);
    @(negedge clk);
    chk("R9 no extra burst", int'(valid_o), 0);
    chk("R9 collide clear", int'(collide_o), 0);

    // R1 unsupported lengths
    for (int l = 0; l < 16; l++) begin
      if (l == 4 || l == 8) continue;
      start_i = 1'b1; len_i = l[3:0]; btype_i = 1'b0; start_col_i = 10'h15;
      @(negedge clk);
      start_i = 1'b0;
      chk("R1 err", int'(err_o), 1);
      chk("R1 no burst", int'(valid_o), 0);
      @(negedge clk);
      chk("R1 err clear", int'(err_o), 0);
      chk("R1 still idle", int'(valid_o), 0);
    end

    // R1 bad length on the last beat ends the burst with an error
    run_burst(6, 4, 0, 3, -1, 1'b0);
    start_i = 1'b1; len_i = 4'd6;
    @(negedge clk);
    start_i = 1'b0;
    chk("R1 err after last", int'(err_o), 1);
    chk("R1 no burst after last", int'(valid_o), 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule